// File: doc/BRIEF.md
# Code-Protected Watchdog Timer

This block watches for a stalled processor. A prescaler divides the block clock down to a counting tick, and an up counter advances on each tick. Software has to keep writing a dedicated restart byte into the code register. If it stops doing so, the counter runs past its top value and the block raises its overflow signal. Depending on a control bit, that signal is either a one-cycle reset pulse for the system or a level interrupt request that stays high until software acknowledges it.

The tick rate comes from one of four prescaler taps. The tap exponent is a base plus twice the tap index. There are two base values, one for the fast clock mode and one for the slow clock mode, and an input pin picks which base applies. Stopping the watchdog takes two steps, so a single stray bus write cannot silence it. Software must first drop the enable bit in the control register, and only then write the stop byte into the code register. A control write that sets the enable bit starts the watchdog again.

Software reaches the block through a synchronous register port with four addresses. Writes take effect on the clock edge. Read data is registered and appears one cycle after the address is presented.

Top module: `wdog_guard`

## Requirements
- R1: After reset, the control register reads 0x93: enable bit 7 set, mode bit 4 set (reset mode), tap field bits 1:0 = 3. The status register reads 0x04 (running bit 2 set). Both outputs are low.
- R2: After a restart, the overflow comes exactly 2^CNT_W * 2^(base + TAP_STEP*tap) clock edges later. The base is FAST_BASE when `slow_sel` is 0 and SLOW_BASE when it is 1.
- R3: Writing 0x4E to address 1 clears both the counter and the prescaler, so the next overflow is a full period after that write.
- R4: Any byte other than 0x4E or 0xB1 written to address 1 leaves the overflow timing unchanged.
- R5: Writing 0xB1 to address 1 while control bit 7 is set has no effect: the watchdog keeps running and still overflows on time.
- R6: Writing 0xB1 after control bit 7 was cleared stops the watchdog. Status bit 2 then reads 0, the counter reads 0 and neither output fires. A control write with bit 7 set restarts the count from zero.
- R7: In reset mode, an overflow drives `rst_pulse_o` high for exactly one cycle, leaves `irq_o` low and sets status bit 0.
- R8: In interrupt mode (control bit 4 = 0), an overflow raises `irq_o` and sets status bits 0 and 1. `irq_o` stays high until a write of 1 to status bit 0 clears both bits. `rst_pulse_o` stays low.
- R9: Read data is registered with one cycle of latency. Address 0 reads control, 1 reads zero, 2 reads status and 3 reads the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_sel | input | 1 | Selects the slow-clock tap base |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Watchdog interrupt request, level |
| rst_pulse_o | output | 1 | Watchdog system reset, one-cycle pulse |

## Verification
The bench aims at the timing of a restart written partway through a prescaler period. A design that cleared only the counter would overflow early, by up to one tick. It also injects random wrong codes, and the stop code while the enable bit is still set, in the middle of a count. A decoder that is too loose would either shift the overflow or silence it. Restarts at random intervals just short of the timeout catch an off-by-one in the wrap detection. In interrupt mode the bench checks that the request is still high tens of cycles after the overflow and that it drops right after the acknowledge write. That exposes an interrupt wrongly built as a pulse, or a reset pulse that leaks into interrupt mode.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam logic [7:0] WDG_CODE_RESTART = 8'h4E;
   localparam logic [7:0] WDG_CODE_STOP    = 8'hB1;

   typedef enum logic [1:0] {
      WDG_A_CTRL  = 2'd0,
      WDG_A_CODE  = 2'd1,
      WDG_A_STAT  = 2'd2,
      WDG_A_COUNT = 2'd3
   } wdg_addr_e;

   typedef struct packed {
      logic       en;
      logic       rst_mode;
      logic [1:0] tap;
   } wdg_ctrl_t;

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int FAST_BASE = 10,
   parameter int SLOW_BASE = 3,
   parameter int TAP_STEP  = 2,
   parameter int NUM_TAPS  = 4,
   parameter int SEL_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             slow_sel,
   input  logic [SEL_W-1:0] tap_sel,
   output logic             tick
);

   localparam int MAX_BASE = (FAST_BASE > SLOW_BASE) ? FAST_BASE : SLOW_BASE;
   localparam int DIV_W    = MAX_BASE + TAP_STEP * (NUM_TAPS - 1);

   if (FAST_BASE < 1 || SLOW_BASE < 1) begin : g_bad_base
      $error("wdg_prescaler: tap bases must be at least 1");
   end
   if (DIV_W > 62) begin : g_bad_width
      $error("wdg_prescaler: divider wider than 62 bits");
   end
   if (NUM_TAPS > (1 << SEL_W)) begin : g_bad_sel
      $error("wdg_prescaler: tap select too narrow");
   end

   logic [DIV_W-1:0]    div_q;
   logic [NUM_TAPS-1:0] fast_hit;
   logic [NUM_TAPS-1:0] slow_hit;

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      localparam int               FE = FAST_BASE + TAP_STEP * g;
      localparam int               SE = SLOW_BASE + TAP_STEP * g;
      localparam logic [DIV_W-1:0] FM = DIV_W'((64'd1 << FE) - 64'd1);
      localparam logic [DIV_W-1:0] SM = DIV_W'((64'd1 << SE) - 64'd1);
      assign fast_hit[g] = ((div_q & FM) == FM);
      assign slow_hit[g] = ((div_q & SM) == SM);
   end

   always_comb begin
      tick = 1'b0;
      for (int i = 0; i < NUM_TAPS; i++) begin
         if (SEL_W'(i) == tap_sel) begin
            tick = slow_sel ? slow_hit[i] : fast_hit[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (clr) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdg_code_decoder.sv
module wdg_code_decoder #(
   parameter logic [7:0] RESTART_CODE = wdg_pkg::WDG_CODE_RESTART,
   parameter logic [7:0] STOP_CODE    = wdg_pkg::WDG_CODE_STOP
) (
   input  logic       code_wr,
   input  logic [7:0] code,
   input  logic       en_bit,
   output logic       restart_hit,
   output logic       stop_hit
);

   if (RESTART_CODE == STOP_CODE) begin : g_bad_codes
      $error("wdg_code_decoder: restart and stop codes must differ");
   end

   always_comb begin
      restart_hit = code_wr && (code == RESTART_CODE);
      // stop only counts once the enable bit has been dropped beforehand
      stop_hit    = code_wr && (code == STOP_CODE) && !en_bit;
   end

endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("wdg_count_core: counter too narrow");
   end

   logic [CNT_W-1:0] cnt_q;

   assign cnt_o = cnt_q;
   assign ovf_o = tick && !clr && (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
   parameter int CNT_W     = 8,
   parameter int FAST_BASE = 10,
   parameter int SLOW_BASE = 3,
   parameter int TAP_STEP  = 2,
   parameter int NUM_TAPS  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slow_sel,
   input  logic       wr_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq_o,
   output logic       rst_pulse_o
);
   import wdg_pkg::*;

   localparam int SEL_W = 2;

   if (CNT_W > 8) begin : g_bad_cnt_w
      $error("wdog_guard: counter must fit the 8-bit read port");
   end
   if (NUM_TAPS > 4 || NUM_TAPS < 1) begin : g_bad_taps
      $error("wdog_guard: tap field holds at most four taps");
   end

   wdg_ctrl_t        ctrl_q;
   logic             ctrl_en;
   logic             ctrl_rst_mode;
   logic             running_q;
   logic             ovf_flag_q;
   logic             irq_q;
   logic             rst_q;
   logic [7:0]       rdata_q;
   logic             wr_ctrl, wr_code, wr_stat;
   logic             restart_hit, stop_hit;
   logic             core_clr;
   logic             pre_tick;
   logic             run_tick;
   logic             ovf;
   logic [CNT_W-1:0] cnt_w;

   assign ctrl_en       = ctrl_q.en;
   assign ctrl_rst_mode = ctrl_q.rst_mode;

   assign wr_ctrl = wr_en && (addr == WDG_A_CTRL);
   assign wr_code = wr_en && (addr == WDG_A_CODE);
   assign wr_stat = wr_en && (addr == WDG_A_STAT);

   wdg_code_decoder u_dec (
      .code_wr     (wr_code),
      .code        (wdata),
      .en_bit      (ctrl_en),
      .restart_hit (restart_hit),
      .stop_hit    (stop_hit)
   );

   assign core_clr = restart_hit || !running_q;
   assign run_tick = pre_tick && running_q;

   wdg_prescaler #(
      .FAST_BASE (FAST_BASE),
      .SLOW_BASE (SLOW_BASE),
      .TAP_STEP  (TAP_STEP),
      .NUM_TAPS  (NUM_TAPS),
      .SEL_W     (SEL_W)
   ) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (core_clr),
      .slow_sel (slow_sel),
      .tap_sel  (ctrl_q.tap),
      .tick     (pre_tick)
   );

   wdg_count_core #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (core_clr),
      .tick  (run_tick),
      .cnt_o (cnt_w),
      .ovf_o (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q.en       <= 1'b1;
         ctrl_q.rst_mode <= 1'b1;
         ctrl_q.tap      <= 2'(NUM_TAPS - 1);
      end else if (wr_ctrl) begin
         ctrl_q.en       <= wdata[7];
         ctrl_q.rst_mode <= wdata[4];
         ctrl_q.tap      <= wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b1;
      end else if (stop_hit) begin
         running_q <= 1'b0;
      end else if (wr_ctrl && wdata[7]) begin
         running_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag_q <= 1'b0;
         irq_q      <= 1'b0;
         rst_q      <= 1'b0;
      end else begin
         rst_q <= ovf && ctrl_q.rst_mode;
         if (ovf) begin
            ovf_flag_q <= 1'b1;
         end else if (wr_stat && wdata[0]) begin
            ovf_flag_q <= 1'b0;
         end
         if (ovf && !ctrl_q.rst_mode) begin
            irq_q <= 1'b1;
         end else if (wr_stat && wdata[0]) begin
            irq_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else begin
         unique case (addr)
            WDG_A_CTRL:  rdata_q <= {ctrl_q.en, 2'b00, ctrl_q.rst_mode, 2'b00, ctrl_q.tap};
            WDG_A_CODE:  rdata_q <= 8'h00;
            WDG_A_STAT:  rdata_q <= {5'b0, running_q, irq_q, ovf_flag_q};
            WDG_A_COUNT: rdata_q <= 8'(cnt_w);
            default:     rdata_q <= 8'h00;
         endcase
      end
   end

   assign rdata       = rdata_q;
   assign irq_o       = irq_q;
   assign rst_pulse_o = rst_q;

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [7:0]       wdata,
   input logic             irq_o,
   input logic             rst_pulse_o,
   input logic             running_q,
   input logic             ctrl_en,
   input logic             ctrl_rst_mode,
   input logic [CNT_W-1:0] cnt_w
);

   logic code_wr;
   logic bad_code;
   logic ack_wr;

   assign code_wr  = wr_en && (addr == 2'd1);
   assign bad_code = code_wr && (wdata != 8'h4E) && (wdata != 8'hB1);
   assign ack_wr   = wr_en && (addr == 2'd2) && wdata[0];

   p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (code_wr && wdata == 8'h4E) |=> (cnt_w == '0));

   p_bad_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_code && running_q && !(&cnt_w)) |=>
         (cnt_w == $past(cnt_w) || cnt_w == $past(cnt_w) + 1'b1));

   p_stop_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (code_wr && wdata == 8'hB1 && ctrl_en) |=> running_q);

   p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !running_q |=> (!rst_pulse_o && !$rose(irq_o)));

   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse_o |=> !rst_pulse_o);

   p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_wr) |=> irq_o);

   p_irq_mode_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> !$past(ctrl_rst_mode));

endmodule

bind wdog_guard wdg_guard_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .addr          (addr),
   .wdata         (wdata),
   .irq_o         (irq_o),
   .rst_pulse_o   (rst_pulse_o),
   .running_q     (running_q),
   .ctrl_en       (ctrl_en),
   .ctrl_rst_mode (ctrl_rst_mode),
   .cnt_w         (cnt_w)
);

// File: tb/sim_wdog_guard.sv
`timescale 1ns/1ps
module sim_wdog_guard;

   localparam int FB = 2;
   localparam int SB = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_o;
   logic       rst_pulse_o;

   int unsigned cyc = 0;
   int          vec = 0;
   int          bad = 0;

   wdog_guard #(.FAST_BASE(FB), .SLOW_BASE(SB)) u0 (
      .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq_o(irq_o), .rst_pulse_o(rst_pulse_o)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int period(bit slow, int tap);
      return 256 * (1 << ((slow ? SB : FB) + 2 * tap));
   endfunction

   task automatic check(string req, int act, int exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      @(negedge clk);
      d = rdata;
   endtask

   // first write starts the timeout; optional write injected mid-count
   task automatic run_ovf(string req, logic [1:0] a0, logic [7:0] d0, int exp,
                          int inj_at, logic [7:0] inj);
      int c0;
      int d;
      wr(a0, d0);
      c0 = int'(cyc);
      forever begin
         d = int'(cyc) - c0;
         if (rst_pulse_o || irq_o) break;
         if (d > exp + 64) break;
         if (d == inj_at) begin
            addr = 2'd1; wdata = inj; wr_en = 1'b1;
         end else if (d == inj_at + 1) begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0;
      check(req, d, exp);
   endtask

   task automatic quiet(int n, output int hits);
      hits = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rst_pulse_o || irq_o) hits++;
      end
   endtask

   initial begin
      logic [7:0] r;
      logic [7:0] code;
      int         hits;
      int         m;
      int unsigned seed;
      seed = $urandom(32'd2718);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R9 map and latency
      rd(2'd0, r); check("R1 ctrl", r, 8'h93);
      rd(2'd2, r); check("R1 status", r, 8'h04);
      check("R1 irq", irq_o, 0);
      check("R1 rst", rst_pulse_o, 0);
      rd(2'd3, r); check("R9 count", r, 8'h00);
      rd(2'd1, r); check("R9 code reads zero", r, 8'h00);

      // R2 fast taps, R7 reset mode
      for (int tap = 0; tap < 2; tap++) begin
         wr(2'd0, 8'h90 | 8'(tap));
         run_ovf("R2 fast tap", 2'd1, 8'h4E, period(0, tap), -5, 8'h00);
         check("R7 irq low in reset mode", irq_o, 0);
         @(negedge clk);
         check("R7 pulse width", rst_pulse_o, 0);
         rd(2'd2, r); check("R7 status", r, 8'h05);
         wr(2'd2, 8'h01);
         rd(2'd2, r); check("R7 status cleared", r, 8'h04);
      end

      // R2 slow base
      slow_sel = 1'b1;
      for (int tap = 0; tap < 2; tap++) begin
         wr(2'd0, 8'h90 | 8'(tap));
         run_ovf("R2 slow tap", 2'd1, 8'h4E, period(1, tap), -5, 8'h00);
      end
      slow_sel = 1'b0;
      wr(2'd2, 8'h01);
      wr(2'd0, 8'h90);

      // R3 restart mid-prescale resets prescaler too
      run_ovf("R3 restart", 2'd1, 8'h4E, 601 + 1 + period(0, 0), 601, 8'h4E);
      for (int k = 0; k < 3; k++) begin
         m = int'($urandom_range(1000, 100));
         run_ovf("R3 random restart", 2'd1, 8'h4E, m + 1 + period(0, 0), m, 8'h4E);
      end

      // R4 other codes ignored
      for (int k = 0; k < 6; k++) begin
         code = 8'($urandom);
         if (code == 8'h4E || code == 8'hB1) code = code ^ 8'h01;
         if (k == 0) code = 8'h4F;
         m = int'($urandom_range(1000, 10));
         run_ovf("R4 bad code", 2'd1, 8'h4E, period(0, 0), m, code);
      end

      // R5 stop code while enabled
      run_ovf("R5 stop ignored", 2'd1, 8'h4E, period(0, 0), 300, 8'hB1);
      rd(2'd2, r); check("R5 still running", r, 8'h05);
      wr(2'd2, 8'h01);

      // R3 periodic restarts keep it quiet
      wr(2'd1, 8'h4E);
      for (int k = 0; k < 20; k++) begin
         quiet(int'($urandom_range(1000, 1)), hits);
         check("R3 periodic restart no overflow", hits, 0);
         wr(2'd1, 8'h4E);
      end

      // R8 interrupt mode
      wr(2'd0, 8'h80);
      run_ovf("R8 irq timing", 2'd1, 8'h4E, period(0, 0), -5, 8'h00);
      check("R8 no reset pulse", rst_pulse_o, 0);
      hits = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!irq_o || rst_pulse_o) hits++;
      end
      check("R8 irq level held", hits, 0);
      rd(2'd2, r); check("R8 status", r, 8'h07);
      wr(2'd2, 8'h01);
      check("R8 irq cleared", irq_o, 0);
      rd(2'd2, r); check("R8 status cleared", r, 8'h04);

      // R6 two-step stop
      wr(2'd0, 8'h10);
      rd(2'd2, r); check("R6 enable drop alone keeps running", r, 8'h04);
      wr(2'd1, 8'hB1);
      rd(2'd2, r); check("R6 stopped", r, 8'h00);
      quiet(2100, hits);
      check("R6 no overflow while stopped", hits, 0);
      rd(2'd3, r); check("R6 counter held", r, 8'h00);
      run_ovf("R6 restart by enable", 2'd0, 8'h90, period(0, 0), -5, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      vec++;
      bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule